// File: doc/BRIEF.md
# Translation Privilege Mode Selector

This block is the entry stage of a virtual-to-physical address translation path. For each access it settles the privilege level under which the access is judged. From that level it decides whether the page-table walk is skipped. When a walk is needed, it drives a request to an external walker carrying the access kind, a supervisor flag and a user-page-protect flag. It then combines the walker's answer with the page offset of the virtual address, or reports an access fault of the matching kind.

An access is offered with `req_valid`. It is accepted when `req_ready` is high, which happens only in state IDLE. The state machine has four states. IDLE waits for a request. WALK_REQ holds the walker request until the walker accepts it. WALK_WAIT waits for the walker's answer. DONE presents the result for exactly one cycle.

The transitions are: IDLE to DONE when a request in machine mode is accepted (bypass); IDLE to WALK_REQ when any other request is accepted; WALK_REQ to WALK_WAIT when `walk_req_ready` is high; WALK_WAIT to DONE when `walk_rsp_valid` is high; DONE to IDLE always. A bypassed access therefore shows `rsp_valid` in the cycle right after acceptance.

Top module: `xlat_front`

## Requirements
- R1: For an instruction fetch (kind code 0), the effective mode is the current privilege, even when the modify-privilege bit is set. Privilege codes are user=0, supervisor=1, machine=3.
- R2: For a load (code 1) or a store (code 2) with the modify-privilege bit set, the effective mode is the previous-privilege field. With the bit clear, it is the current privilege.
- R3: `walk_pum` is 1 only for a load or store whose effective mode is supervisor and whose protect-user-memory bit is set. It is 0 in every other case, including fetches.
- R4: When the virtual-memory mode field equals 0 (bare), the access is treated as machine mode and bypassed, whatever the privilege inputs say.
- R5: A machine-mode access makes no walker request. In the cycle after acceptance it gives `rsp_valid=1` and `rsp_bypass=1`. In that response `rsp_paddr` is the virtual address with every bit at or above XLEN cleared.
- R6: When a walk is requested, `walk_super` is 1 exactly when the effective mode is above user. `walk_vaddr` and `walk_kind` repeat the access.
- R7: When the walker succeeds, `rsp_paddr` is `walk_rsp_base` OR'ed with the low PG_SHIFT bits of the virtual address. `rsp_fault` is 0 and `rsp_bypass` is 0.
- R8: When the walker fails, the response has `rsp_fault=1` and `rsp_paddr=0`. `rsp_fault_addr` is the virtual address. `rsp_fault_kind` is 0 for a fetch, 1 for a load and 2 for a store.
- R9: While a walk is outstanding, `req_ready` stays 0. `walk_req_valid` holds with a stable `walk_vaddr` until `walk_req_ready` is seen.
- R10: Out of reset, `req_ready=1`, `rsp_valid=0` and `walk_req_valid=0`. `rsp_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Block can accept an access |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_vaddr | input | ADDR_W | Virtual address |
| cur_priv | input | 2 | Current privilege level |
| st_mprv | input | 1 | Modify-privilege bit |
| st_mpp | input | 2 | Previous-privilege field |
| st_pum | input | 1 | Protect-user-memory bit |
| st_vm | input | VM_W | Virtual-memory mode field, 0 is bare |
| walk_req_valid | output | 1 | Walk request pending |
| walk_req_ready | input | 1 | Walker takes the request |
| walk_vaddr | output | ADDR_W | Address to translate |
| walk_kind | output | 2 | Access kind for the walker |
| walk_super | output | 1 | Effective mode above user |
| walk_pum | output | 1 | User pages forbidden for this access |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_ok | input | 1 | Walk succeeded |
| walk_rsp_base | input | ADDR_W | Physical page base from the walker |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_bypass | output | 1 | Result came from the machine-mode bypass |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_fault | output | 1 | Access fault |
| rsp_fault_kind | output | 2 | Fault kind, same codes as req_kind |
| rsp_fault_addr | output | ADDR_W | Faulting virtual address |

## Verification
A wrong effective mode shows on the walker port in the cycle after acceptance. It appears there either as a wrong `walk_super` or `walk_pum`, or as a walk request where a bypass was due. A bypass that was due and is missed also shows as `rsp_valid` failing to rise one cycle after acceptance. A state machine that leaves WALK_REQ early or stays in DONE too long shows within one cycle. The first appears as a dropped `walk_req_valid` or an early `req_ready`. The second appears as a doubled `rsp_valid`. A wrong merge or fault encoding shows only in the single DONE cycle, so each response field is compared exactly there.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_HYP   = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WALK_REQ  = 2'd1,
        ST_WALK_WAIT = 2'd2,
        ST_DONE      = 2'd3
    } fsm_e;

endpackage

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel
    import xlat_pkg::*;
#(
    parameter int VM_W = 5
) (
    input  acc_kind_e        kind_i,
    input  priv_e            cur_priv_i,
    input  logic             mprv_i,
    input  priv_e            mpp_i,
    input  logic             pum_bit_i,
    input  logic [VM_W-1:0]  vm_i,
    output logic             bypass_o,
    output logic             super_o,
    output logic             pum_o
);

    priv_e pre_mode;
    priv_e eff_mode;
    logic  is_data;
    logic  vm_bare;

    always_comb begin
        is_data  = (kind_i != ACC_FETCH);
        vm_bare  = (vm_i == '0);
        pre_mode = (is_data && mprv_i) ? mpp_i : cur_priv_i;
        pum_o    = is_data && (pre_mode == PRV_SUPER) && pum_bit_i;
        eff_mode = vm_bare ? PRV_MACH : pre_mode;
        bypass_o = (eff_mode == PRV_MACH);
        super_o  = (eff_mode != PRV_USER);
    end

endmodule

// File: rtl/xlat_merge.sv
module xlat_merge
    import xlat_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PG_SHIFT = 12
) (
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [PG_SHIFT-1:0] offset_i,
    input  logic                ok_i,
    input  acc_kind_e           kind_i,
    output logic [ADDR_W-1:0]   paddr_o,
    output logic                fault_o,
    output acc_kind_e           fault_kind_o
);

    localparam int HI_W = ADDR_W - PG_SHIFT;

    always_comb begin
        paddr_o = ok_i ? (base_i | {{HI_W{1'b0}}, offset_i}) : '0;
        fault_o = !ok_i;
        unique case (kind_i)
            ACC_FETCH: fault_kind_o = ACC_FETCH;
            ACC_STORE: fault_kind_o = ACC_STORE;
            default:   fault_kind_o = ACC_LOAD;
        endcase
    end

endmodule

// File: rtl/xlat_front.sv
module xlat_front
    import xlat_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int XLEN     = 32,
    parameter int PG_SHIFT = 12,
    parameter int VM_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        cur_priv,
    input  logic              st_mprv,
    input  logic [1:0]        st_mpp,
    input  logic              st_pum,
    input  logic [VM_W-1:0]   st_vm,
    output logic              walk_req_valid,
    input  logic              walk_req_ready,
    output logic [ADDR_W-1:0] walk_vaddr,
    output logic [1:0]        walk_kind,
    output logic              walk_super,
    output logic              walk_pum,
    input  logic              walk_rsp_valid,
    input  logic              walk_rsp_ok,
    input  logic [ADDR_W-1:0] walk_rsp_base,
    output logic              rsp_valid,
    output logic              rsp_bypass,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_kind,
    output logic [ADDR_W-1:0] rsp_fault_addr
);

    logic [ADDR_W-1:0] xlen_mask;

    generate
        if (XLEN >= ADDR_W) begin : g_full_mask
            assign xlen_mask = '1;
        end else begin : g_part_mask
            assign xlen_mask = {{(ADDR_W-XLEN){1'b0}}, {XLEN{1'b1}}};
        end
    endgenerate

    fsm_e state_q, state_d;

    logic sel_bypass, sel_super, sel_pum;
    logic accept;

    acc_kind_e         cap_kind;
    logic [ADDR_W-1:0] cap_vaddr;
    logic              cap_super, cap_pum;

    logic [ADDR_W-1:0] mrg_paddr;
    logic              mrg_fault;
    acc_kind_e         mrg_fkind;

    assign accept = req_valid && (state_q == ST_IDLE);

    xlat_mode_sel #(.VM_W(VM_W)) i_mode_sel (
        .kind_i     (acc_kind_e'(req_kind)),
        .cur_priv_i (priv_e'(cur_priv)),
        .mprv_i     (st_mprv),
        .mpp_i      (priv_e'(st_mpp)),
        .pum_bit_i  (st_pum),
        .vm_i       (st_vm),
        .bypass_o   (sel_bypass),
        .super_o    (sel_super),
        .pum_o      (sel_pum)
    );

    xlat_merge #(.ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT)) i_merge (
        .base_i       (walk_rsp_base),
        .offset_i     (cap_vaddr[PG_SHIFT-1:0]),
        .ok_i         (walk_rsp_ok),
        .kind_i       (cap_kind),
        .paddr_o      (mrg_paddr),
        .fault_o      (mrg_fault),
        .fault_kind_o (mrg_fkind)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = sel_bypass ? ST_DONE : ST_WALK_REQ;
            ST_WALK_REQ:  if (walk_req_ready) state_d = ST_WALK_WAIT;
            ST_WALK_WAIT: if (walk_rsp_valid) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured access and registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_kind       <= ACC_FETCH;
            cap_vaddr      <= '0;
            cap_super      <= 1'b0;
            cap_pum        <= 1'b0;
            rsp_bypass     <= 1'b0;
            rsp_paddr      <= '0;
            rsp_fault      <= 1'b0;
            rsp_fault_kind <= 2'd0;
            rsp_fault_addr <= '0;
        end else begin
            if (accept) begin
                cap_kind  <= acc_kind_e'(req_kind);
                cap_vaddr <= req_vaddr;
                cap_super <= sel_super;
                cap_pum   <= sel_pum;
                if (sel_bypass) begin
                    rsp_bypass     <= 1'b1;
                    rsp_paddr      <= req_vaddr & xlen_mask;
                    rsp_fault      <= 1'b0;
                    rsp_fault_kind <= 2'd0;
                    rsp_fault_addr <= '0;
                end
            end
            if (state_q == ST_WALK_WAIT && walk_rsp_valid) begin
                rsp_bypass     <= 1'b0;
                rsp_paddr      <= mrg_paddr;
                rsp_fault      <= mrg_fault;
                rsp_fault_kind <= mrg_fault ? mrg_fkind : 2'd0;
                rsp_fault_addr <= mrg_fault ? cap_vaddr : '0;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        walk_req_valid = (state_q == ST_WALK_REQ);
        rsp_valid      = (state_q == ST_DONE);
        walk_vaddr     = cap_vaddr;
        walk_kind      = cap_kind;
        walk_super     = cap_super;
        walk_pum       = cap_pum;
    end

    // R9: walk request held with stable address until taken
    p_walk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_vaddr));

    // R9: no new access accepted while a walk is outstanding
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !req_ready);

    // R10: response is a single-cycle pulse
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5: a bypassed access answers in the next cycle without a walk
    p_bypass_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && sel_bypass |=> rsp_valid && rsp_bypass && !walk_req_valid);

    // R3: page protection never flagged for fetches
    p_pum_scope_r3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid && walk_pum |-> walk_kind != ACC_FETCH && walk_super);

    // R8: a fault is never a bypass result
    p_fault_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> !rsp_bypass && rsp_paddr == '0);

endmodule

// File: tb/test_xlat_front.sv
module test_xlat_front;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 64;
    localparam int XLEN       = 32;
    localparam int PG_SHIFT   = 12;
    localparam int VM_W       = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = 2'd0;
    logic [ADDR_W-1:0] req_vaddr = '0;
    logic [1:0]        cur_priv = 2'd0;
    logic              st_mprv = 1'b0;
    logic [1:0]        st_mpp = 2'd0;
    logic              st_pum = 1'b0;
    logic [VM_W-1:0]   st_vm = '0;
    logic              walk_req_valid;
    logic              walk_req_ready = 1'b0;
    logic [ADDR_W-1:0] walk_vaddr;
    logic [1:0]        walk_kind;
    logic              walk_super;
    logic              walk_pum;
    logic              walk_rsp_valid = 1'b0;
    logic              walk_rsp_ok = 1'b0;
    logic [ADDR_W-1:0] walk_rsp_base = '0;
    logic              rsp_valid;
    logic              rsp_bypass;
    logic [ADDR_W-1:0] rsp_paddr;
    logic              rsp_fault;
    logic [1:0]        rsp_fault_kind;
    logic [ADDR_W-1:0] rsp_fault_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit rsp_expected = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_front #(.ADDR_W(ADDR_W), .XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .VM_W(VM_W)) i_xlat_front (
        .clk, .rst_n, .req_valid, .req_ready, .req_kind, .req_vaddr, .cur_priv,
        .st_mprv, .st_mpp, .st_pum, .st_vm, .walk_req_valid, .walk_req_ready,
        .walk_vaddr, .walk_kind, .walk_super, .walk_pum, .walk_rsp_valid,
        .walk_rsp_ok, .walk_rsp_base, .rsp_valid, .rsp_bypass, .rsp_paddr,
        .rsp_fault, .rsp_fault_kind, .rsp_fault_addr
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison: a response may only appear where the model expects one (R10)
    always @(negedge clk) begin
        cycles++;
        if (rst_n && rsp_valid && !rsp_expected) begin
            errors++;
            checks++;
            $display("FAIL R10 unexpected rsp_valid actual=1 expected=0");
        end
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_req(input logic [1:0] kind, input logic [1:0] prv, input bit mprv,
                           input logic [1:0] mpp, input bit pum, input logic [VM_W-1:0] vm,
                           input logic [63:0] va, input bit ok, input logic [63:0] base,
                           input int delay);
        int eff;
        bit is_data, exp_pum, exp_byp, exp_sup;
        logic [63:0] exp_pa;
        is_data = (kind != 2'd0);
        eff     = (is_data && mprv) ? int'(mpp) : int'(prv);
        exp_pum = is_data && eff == 1 && pum;
        if (vm == 0) eff = 3;
        exp_byp = (eff == 3);
        exp_sup = (eff > 0);

        @(negedge clk);
        req_kind = kind; cur_priv = prv; st_mprv = mprv; st_mpp = mpp;
        st_pum = pum; st_vm = vm; req_vaddr = va; req_valid = 1'b1;
        check("R10 req_ready idle", {63'd0, req_ready}, 64'd1);
        @(posedge clk);
        if (exp_byp) rsp_expected = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_byp) begin
            exp_pa = va & ((64'd1 << XLEN) - 64'd1);
            check("R4/R5 rsp_valid", {63'd0, rsp_valid}, 64'd1);
            check("R5 rsp_bypass", {63'd0, rsp_bypass}, 64'd1);
            check("R5 paddr masked", rsp_paddr, exp_pa);
            check("R5 no walk", {63'd0, walk_req_valid}, 64'd0);
            @(posedge clk);
            rsp_expected = 1'b0;
            @(negedge clk);
            check("R10 pulse", {63'd0, rsp_valid}, 64'd0);
        end else begin
            check("R5 walk requested", {63'd0, walk_req_valid}, 64'd1);
            check("R1/R2/R6 walk_super", {63'd0, walk_super}, {63'd0, exp_sup});
            check("R3 walk_pum", {63'd0, walk_pum}, {63'd0, exp_pum});
            check("R6 walk_vaddr", walk_vaddr, va);
            check("R6 walk_kind", {62'd0, walk_kind}, {62'd0, kind});
            check("R9 req_ready busy", {63'd0, req_ready}, 64'd0);
            for (int i = 0; i < delay; i++) begin
                @(negedge clk);
                check("R9 walk held", {63'd0, walk_req_valid}, 64'd1);
                check("R9 walk_vaddr stable", walk_vaddr, va);
            end
            walk_req_ready = 1'b1;
            @(negedge clk);
            walk_req_ready = 1'b0;
            check("R9 walk dropped after take", {63'd0, walk_req_valid}, 64'd0);
            check("R9 still busy", {63'd0, req_ready}, 64'd0);
            walk_rsp_valid = 1'b1; walk_rsp_ok = ok; walk_rsp_base = base;
            @(posedge clk);
            rsp_expected = 1'b1;
            @(negedge clk);
            walk_rsp_valid = 1'b0;
            check("R7/R8 rsp_valid", {63'd0, rsp_valid}, 64'd1);
            check("R7 rsp_bypass", {63'd0, rsp_bypass}, 64'd0);
            if (ok) begin
                exp_pa = base | (va & ((64'd1 << PG_SHIFT) - 64'd1));
                check("R7 paddr merge", rsp_paddr, exp_pa);
                check("R7 no fault", {63'd0, rsp_fault}, 64'd0);
            end else begin
                check("R8 fault", {63'd0, rsp_fault}, 64'd1);
                check("R8 fault kind", {62'd0, rsp_fault_kind}, {62'd0, kind});
                check("R8 fault addr", rsp_fault_addr, va);
                check("R8 paddr zero", rsp_paddr, 64'd0);
            end
            @(posedge clk);
            rsp_expected = 1'b0;
            @(negedge clk);
            check("R10 pulse", {63'd0, rsp_valid}, 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset req_ready", {63'd0, req_ready}, 64'd1);
        check("R10 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R10 reset walk_req_valid", {63'd0, walk_req_valid}, 64'd0);
        rst_n = 1'b1;

        // R5: machine-mode fetch with high address bits set
        run_req(2'd0, 2'd3, 1'b0, 2'd0, 1'b0, 5'd8, 64'hFFFF_FFFF_8000_1234, 1'b1, 64'd0, 0);
        // R4: bare mode forces bypass for a user load
        run_req(2'd1, 2'd0, 1'b0, 2'd0, 1'b1, 5'd0, 64'h0000_0012_3456_789A, 1'b1, 64'd0, 0);
        // R1: user fetch ignores modify-privilege
        run_req(2'd0, 2'd0, 1'b1, 2'd3, 1'b1, 5'd8, 64'h0000_0000_4000_0ABC, 1'b1, 64'h0000_0000_9000_0000, 2);
        // R2, R3: user load takes supervisor from previous-privilege, protect set
        run_req(2'd1, 2'd0, 1'b1, 2'd1, 1'b1, 5'd8, 64'h0000_0000_0001_2FFF, 1'b1, 64'h0000_0001_0000_0000, 0);
        // R3: supervisor fetch with protect bit gets no protection flag
        run_req(2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 5'd9, 64'h0000_0000_0002_0001, 1'b1, 64'h0000_0000_0000_5000, 3);
        // R6, R7: supervisor store, no protect
        run_req(2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 5'd9, 64'h0000_0000_7777_7123, 1'b1, 64'h0000_00AB_CDEF_0000, 1);
        // R2: machine load lowered to user through previous-privilege
        run_req(2'd1, 2'd3, 1'b1, 2'd0, 1'b1, 5'd8, 64'h0000_0000_0000_0F00, 1'b1, 64'h0000_0000_1234_5000, 0);
        // R2: machine store with previous-privilege machine bypasses
        run_req(2'd2, 2'd3, 1'b1, 2'd3, 1'b0, 5'd8, 64'hABCD_0000_0000_0040, 1'b1, 64'd0, 0);
        // R8: faults of each kind
        run_req(2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 5'd8, 64'h0000_0000_DEAD_B000, 1'b0, 64'd0, 1);
        run_req(2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 5'd8, 64'h0000_0000_CAFE_0008, 1'b0, 64'd0, 0);
        run_req(2'd2, 2'd3, 1'b1, 2'd1, 1'b1, 5'd8, 64'h0000_0000_BEEF_0FF0, 1'b0, 64'd0, 2);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule